// File: doc/BRIEF.md
# Dual I/O Window Address Decoder

This block decodes bus I/O cycles against two programmable address windows. Each window has a base register and a limit register. Software reaches all four registers through a small configuration port, which carries a dword offset, write data, byte-lane enables and read data. For every I/O address presented, the block reports whether the address lands in window 0 or window 1. It also raises a flag when either window matches.

The decode is 16-bit only, at doubleword granularity. Only address bits 15:2 take part in the range compare. Any address with a nonzero upper half misses. A window has no enable bit of its own. Setting its limit below its base switches it off. A global decode enable, fed from the command register, gates both windows. Configuration writes take effect at the next rising clock edge. Read data and the hit outputs are combinational.

Top module: `dual_io_window_decode`

## Requirements
- R1: After reset each base register reads 0x0000FFFC and each limit register reads 0x00000000. With these values no address hits.
- R2: The registers sit at these byte offsets: window 0 base at 2Ch, window 0 limit at 30h, window 1 base at 34h, window 1 limit at 38h. The dword offset port carries the byte offset divided by four. A read of any other offset returns zero.
- R3: Register bits 31:16 and bits 1:0 always read zero. Writing ones to them has no effect.
- R4: On a write, enable lane 0 updates bits 7:2 and enable lane 1 updates bits 15:8. Lanes 2 and 3 change nothing.
- R5: A window hits when address[31:16] is zero and base[15:2] <= address[15:2] <= limit[15:2]. Both bounds are inclusive and address bits 1:0 are ignored.
- R6: An address with any of bits 31:16 set never hits.
- R7: While the decode enable input is low, no window hits.
- R8: A window whose limit is below its base never hits.
- R9: When base equals limit, the window covers exactly the four bytes of that one doubleword.
- R10: The window hit output is one-hot or zero. Bit 0 means window 0 and bit 1 means window 1. If both windows match, only bit 0 is set. The any-hit output is the OR of the matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSel | input | 1 | Configuration access strobe |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgDwordAddr | input | 6 | Configuration byte offset divided by four |
| cfgWrData | input | 32 | Configuration write data |
| cfgByteEn | input | 4 | Write byte-lane enables |
| cfgRdData | output | 32 | Configuration read data, zero when there is no read |
| ioDecodeEn | input | 1 | Global I/O decode enable (command bit 0) |
| ioAddr | input | 32 | I/O cycle address under test |
| winHit | output | 2 | One-hot window match, window 0 wins |
| anyHit | output | 1 | Address lies in some window |

## Verification
The range compare is driven with two overlapping windows. The addresses used sit just inside and just outside each edge, have nonzero low bits, or land in the overlap, which separates an inclusive compare from an exclusive one and tests the priority rule. The same in-range addresses are then repeated with upper-half bits set or with the decode enable low, so that the R6 and R7 gating shows up on its own. Directed cases cover an inverted window and a window one doubleword wide. A write sequence uses each byte-lane combination in turn, which shows whether each lane reaches only its own bits.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int NUM_WIN  = 2;
  localparam int ADDR_W   = 32;
  localparam int CMP_LSB  = 2;
  localparam int CMP_MSB  = 15;
  localparam int CMP_W    = CMP_MSB - CMP_LSB + 1;
  localparam int CFG_AW   = 6;
  localparam int FIRST_DW = 11;   // byte offset 2Ch / 4
  localparam int BE_W     = ADDR_W / 8;

  // Strobes from control to datapath, one bit per window each.
  typedef struct packed {
    logic [NUM_WIN-1:0] wrBase;
    logic [NUM_WIN-1:0] wrLimit;
    logic [NUM_WIN-1:0] rdBase;
    logic [NUM_WIN-1:0] rdLimit;
  } winStrobe_t;

  // Merge new data into a compare field, honouring byte-lane enables.
  function automatic logic [CMP_W-1:0] mergeLanes(
    input logic [CMP_W-1:0]  oldVal,
    input logic [ADDR_W-1:0] data,
    input logic [BE_W-1:0]   be
  );
    logic [CMP_W-1:0] res;
    res = oldVal;
    for (int i = CMP_LSB; i <= CMP_MSB; i++) begin
      if (be[i/8]) res[i-CMP_LSB] = data[i];
    end
    return res;
  endfunction

  // Place a compare field at its bus bit position; other bits read zero.
  function automatic logic [ADDR_W-1:0] placeField(input logic [CMP_W-1:0] f);
    return ADDR_W'(f) << CMP_LSB;
  endfunction

endpackage

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSel,
  input  logic              cfgWrite,
  input  logic [CFG_AW-1:0] cfgDwordAddr,
  output winStrobe_t        strobe
);

  logic wrAccess;
  logic rdAccess;

  assign wrAccess = cfgSel && cfgWrite;
  assign rdAccess = cfgSel && !cfgWrite;

  // Window w: base at FIRST_DW + 2w, limit right after it.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
    localparam logic [CFG_AW-1:0] BASE_DW  = CFG_AW'(FIRST_DW + 2*w);
    localparam logic [CFG_AW-1:0] LIMIT_DW = CFG_AW'(FIRST_DW + 2*w + 1);
    logic baseSel;
    logic limitSel;
    assign baseSel  = (cfgDwordAddr == BASE_DW);
    assign limitSel = (cfgDwordAddr == LIMIT_DW);
    assign strobe.wrBase[w]  = wrAccess && baseSel;
    assign strobe.wrLimit[w] = wrAccess && limitSel;
    assign strobe.rdBase[w]  = rdAccess && baseSel;
    assign strobe.rdLimit[w] = rdAccess && limitSel;
  end

  // R2: at most one register is addressed per access
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrBase, strobe.wrLimit, strobe.rdBase, strobe.rdLimit}));

  // R2: an offset outside the register block produces no strobe
  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDwordAddr < CFG_AW'(FIRST_DW) || cfgDwordAddr >= CFG_AW'(FIRST_DW + 2*NUM_WIN))
    |-> (strobe == '0));

endmodule

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  winStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             wrData,
  input  logic [BE_W-1:0]               wrBe,
  output logic [NUM_WIN-1:0][CMP_W-1:0] baseQ,
  output logic [NUM_WIN-1:0][CMP_W-1:0] limitQ,
  output logic [ADDR_W-1:0]             rdData
);

  localparam logic [CMP_W-1:0] BASE_RST  = '1;
  localparam logic [CMP_W-1:0] LIMIT_RST = '0;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[w]  <= BASE_RST;
        limitQ[w] <= LIMIT_RST;
      end else begin
        if (strobe.wrBase[w])  baseQ[w]  <= mergeLanes(baseQ[w], wrData, wrBe);
        if (strobe.wrLimit[w]) limitQ[w] <= mergeLanes(limitQ[w], wrData, wrBe);
      end
    end

    // R4: a write with neither low lane enabled leaves the register unchanged
    a_r4_base_lanes_off: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrBase[w] && wrBe[1:0] == 2'b00) |=> $stable(baseQ[w]));
    a_r4_limit_lanes_off: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrLimit[w] && wrBe[1:0] == 2'b00) |=> $stable(limitQ[w]));
    // R4: registers move only when written
    a_r4_base_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrBase[w] |=> $stable(baseQ[w]));
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (strobe.rdBase[w])  rdData = rdData | placeField(baseQ[w]);
      if (strobe.rdLimit[w]) rdData = rdData | placeField(limitQ[w]);
    end
  end

  logic unusedWr;
  assign unusedWr = ^{wrData[ADDR_W-1:CMP_MSB+1], wrData[CMP_LSB-1:0], wrBe};

  // R3: bits outside the compare field always read zero
  a_r3_fixed_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[ADDR_W-1:CMP_MSB+1] == '0 && rdData[CMP_LSB-1:0] == '0);

endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          decodeEn,
  input  logic [ADDR_W-1:0]             ioAddr,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] baseQ,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] limitQ,
  output logic [NUM_WIN-1:0]            winHit,
  output logic                          anyHit
);

  logic [CMP_W-1:0]   dwAddr;
  logic               upperClear;
  logic [NUM_WIN-1:0] rawHit;

  assign dwAddr     = ioAddr[CMP_MSB:CMP_LSB];
  assign upperClear = (ioAddr[ADDR_W-1:CMP_MSB+1] == '0);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic aboveBase;
    logic belowLimit;
    assign aboveBase  = (dwAddr >= baseQ[w]);
    assign belowLimit = (dwAddr <= limitQ[w]);
    assign rawHit[w]  = decodeEn && upperClear && aboveBase && belowLimit;

    // R8: an inverted window never matches
    a_r8_inverted_miss: assert property (@(posedge clk) disable iff (!rstN)
      (limitQ[w] < baseQ[w]) |-> !rawHit[w]);
  end

  // Fixed priority: lowest-numbered matching window wins.
  always_comb begin
    logic taken;
    taken  = 1'b0;
    winHit = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rawHit[w] && !taken) begin
        winHit[w] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

  assign anyHit = |rawHit;

  logic unusedLow;
  assign unusedLow = ^ioAddr[CMP_LSB-1:0];

  // R10: at most one window reported
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winHit));
  // R10: the flag agrees with the one-hot vector
  a_r10_flag_match: assert property (@(posedge clk) disable iff (!rstN)
    anyHit == (winHit != '0));
  // R10: window 0 takes precedence when it matches
  a_r10_prio: assert property (@(posedge clk) disable iff (!rstN)
    rawHit[0] |-> winHit[0]);
  // R6: upper address half nonzero never hits
  a_r6_upper_miss: assert property (@(posedge clk) disable iff (!rstN)
    !upperClear |-> !anyHit);
  // R7: decode disabled, nothing hits
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !decodeEn |-> winHit == '0);

endmodule

// File: rtl/dual_io_window_decode.sv
module dual_io_window_decode
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSel,
  input  logic              cfgWrite,
  input  logic [CFG_AW-1:0] cfgDwordAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [BE_W-1:0]   cfgByteEn,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              ioDecodeEn,
  input  logic [ADDR_W-1:0] ioAddr,
  output logic [NUM_WIN-1:0] winHit,
  output logic              anyHit
);

  winStrobe_t                    strobe;
  logic [NUM_WIN-1:0][CMP_W-1:0] baseQ;
  logic [NUM_WIN-1:0][CMP_W-1:0] limitQ;

  iowin_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgSel       (cfgSel),
    .cfgWrite     (cfgWrite),
    .cfgDwordAddr (cfgDwordAddr),
    .strobe       (strobe)
  );

  iowin_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (cfgWrData),
    .wrBe   (cfgByteEn),
    .baseQ  (baseQ),
    .limitQ (limitQ),
    .rdData (cfgRdData)
  );

  iowin_match u_match (
    .clk      (clk),
    .rstN     (rstN),
    .decodeEn (ioDecodeEn),
    .ioAddr   (ioAddr),
    .baseQ    (baseQ),
    .limitQ   (limitQ),
    .winHit   (winHit),
    .anyHit   (anyHit)
  );

endmodule

// File: tb/dual_io_window_decode_test.sv
`timescale 1ns/1ps
module dual_io_window_decode_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSel = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [5:0]  cfgDwordAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgRdData;
  logic        ioDecodeEn = 1'b0;
  logic [31:0] ioAddr = '0;
  logic [1:0]  winHit;
  logic        anyHit;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;   // 50 MHz

  dual_io_window_decode uut (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWrite(cfgWrite),
    .cfgDwordAddr(cfgDwordAddr), .cfgWrData(cfgWrData), .cfgByteEn(cfgByteEn),
    .cfgRdData(cfgRdData), .ioDecodeEn(ioDecodeEn), .ioAddr(ioAddr),
    .winHit(winHit), .anyHit(anyHit)
  );

  // {address, decode enable, expected one-hot hit}
  // Windows: w0 1000h..10FCh, w1 10F0h..2000h (overlap tests priority)
  localparam int NVEC = 10;
  localparam logic [34:0] VEC [NVEC] = '{
    {32'h0000_1000, 1'b1, 2'b01},  // R5 lower edge of w0
    {32'h0000_0FFC, 1'b1, 2'b00},  // R5 just below w0
    {32'h0000_10FF, 1'b1, 2'b01},  // R10 overlap, low bits set, w0 wins
    {32'h0000_1100, 1'b1, 2'b10},  // R5 inside w1 only
    {32'h0000_2003, 1'b1, 2'b10},  // R5 upper edge of w1
    {32'h0000_2004, 1'b1, 2'b00},  // R5 just above w1
    {32'h0001_1000, 1'b1, 2'b00},  // R6 bit 16 set
    {32'h8000_1100, 1'b1, 2'b00},  // R6 bit 31 set
    {32'h0000_1000, 1'b0, 2'b00},  // R7 decode off
    {32'h0000_1100, 1'b0, 2'b00}   // R7 decode off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgSel = 1'b1; cfgWrite = 1'b1; cfgDwordAddr = off[7:2];
    cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgSel = 1'b0; cfgWrite = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRdCheck(input string req, input logic [7:0] off, input logic [31:0] exp);
    @(negedge clk);
    cfgSel = 1'b1; cfgWrite = 1'b0; cfgDwordAddr = off[7:2];
    #5 check(req, cfgRdData, exp);
    @(negedge clk);
    cfgSel = 1'b0;
  endtask

  task automatic hitCheck(input string req, input logic [31:0] a, input logic en,
                          input logic [1:0] exp);
    @(negedge clk);
    ioAddr = a; ioDecodeEn = en;
    #5;
    check(req, {30'd0, winHit}, {30'd0, exp});
    check(req, {31'd0, anyHit}, {31'd0, |exp});
  endtask

  initial begin : watchdog
    #2_000_000;
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;

    // R1: reset values and no hit
    cfgRdCheck("R1", 8'h2C, 32'h0000_FFFC);
    cfgRdCheck("R1", 8'h30, 32'h0000_0000);
    cfgRdCheck("R1", 8'h34, 32'h0000_FFFC);
    cfgRdCheck("R1", 8'h38, 32'h0000_0000);
    hitCheck("R1", 32'h0000_FFFC, 1'b1, 2'b00);
    hitCheck("R1", 32'h0000_0000, 1'b1, 2'b00);

    // R2: other offsets read zero; no read strobe reads zero
    cfgRdCheck("R2", 8'h28, 32'h0);
    cfgRdCheck("R2", 8'h3C, 32'h0);
    @(negedge clk); #5 check("R2", cfgRdData, 32'h0);

    // program table windows
    cfgWr(8'h2C, 32'h0000_1000, 4'hF);
    cfgWr(8'h30, 32'h0000_10FC, 4'hF);
    cfgWr(8'h34, 32'h0000_10F0, 4'hF);
    cfgWr(8'h38, 32'h0000_2000, 4'hF);
    cfgRdCheck("R2", 8'h30, 32'h0000_10FC);
    cfgRdCheck("R2", 8'h34, 32'h0000_10F0);

    for (int i = 0; i < NVEC; i++) begin
      hitCheck("R5/R6/R7/R10 vector", VEC[i][34:3], VEC[i][2], VEC[i][1:0]);
    end

    // R3: fixed bits stay zero
    cfgWr(8'h38, 32'hFFFF_FFFF, 4'hF);
    cfgRdCheck("R3", 8'h38, 32'h0000_FFFC);

    // R4: byte lanes
    cfgWr(8'h2C, 32'h0000_ABCD, 4'b0001);
    cfgRdCheck("R4", 8'h2C, 32'h0000_10CC);
    cfgWr(8'h2C, 32'h0000_ABCD, 4'b0010);
    cfgRdCheck("R4", 8'h2C, 32'h0000_ABCC);
    cfgWr(8'h2C, 32'hFFFF_FFFF, 4'b1100);
    cfgRdCheck("R4", 8'h2C, 32'h0000_ABCC);

    // R8: inverted window 0
    cfgWr(8'h2C, 32'h0000_5000, 4'hF);
    cfgWr(8'h30, 32'h0000_4FFC, 4'hF);
    cfgWr(8'h34, 32'h0000_8000, 4'hF);
    cfgWr(8'h38, 32'h0000_0000, 4'hF);
    hitCheck("R8", 32'h0000_5000, 1'b1, 2'b00);
    hitCheck("R8", 32'h0000_4FFC, 1'b1, 2'b00);

    // R9: single doubleword window 1
    cfgWr(8'h34, 32'h0000_3000, 4'hF);
    cfgWr(8'h38, 32'h0000_3000, 4'hF);
    hitCheck("R9", 32'h0000_3000, 1'b1, 2'b10);
    hitCheck("R9", 32'h0000_3003, 1'b1, 2'b10);
    hitCheck("R9", 32'h0000_2FFC, 1'b1, 2'b00);
    hitCheck("R9", 32'h0000_3004, 1'b1, 2'b00);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule